// File: doc/BRIEF.md
# Compare-Driven Output Flag Generator

This block produces the output flag of one timer channel. A counter core next to it supplies single-cycle event strobes: a hit on the first compare register, a hit on the second compare register, an edge seen on the secondary input, and a counter rollover. It also supplies two levels: one saying that counting is active, and one per-count tick used for the gated-clock behaviour. A 3-bit mode input chooses how these events move a one-bit internal flag. The flag is registered, so every change shows one clock after the edge that sampled its cause.

Around the mode logic sit the cross-channel features. With forcing enabled, a compare broadcast coming from another channel loads a chosen level into the flag. With master mode enabled, this channel publishes its own compare hits, registered, for its neighbours. The pin itself applies an optional polarity inversion to the flag. Debug actions 2 and 3 pull the pin low without disturbing the stored flag. An idle request loads a fixed level and restarts the alternating-compare sequence.

Top module: `cmp_flag_out`

## Requirements
- R1: While reset is low and on the first cycle after it, flagState is 0, bcastOut is 0 and flagOut equals invertOut (with no debug force applied).
- R2: With outMode = 0, flagState in each cycle equals the cntActive value sampled at the previous clock edge.
- R3: With outMode = 1, a cmp1Hit clears the flag. With outMode = 2, it sets the flag. With outMode = 3, it inverts the flag. In these modes cmp2Hit, secEdge and rollover leave the flag unchanged, and a cycle with no cmp1Hit holds it.
- R4: With outMode = 4, the flag toggles on compare hits taken from the two compare registers in turn. After reset or an idle request, the first register in the turn is register 1 (cmp1Hit). A hit from the register that is not currently due is ignored.
- R5: With outMode = 5, cmp1Hit sets the flag and secEdge clears it. When both arrive in the same cycle, the set wins.
- R6: With outMode = 6, cmp1Hit sets the flag and rollover clears it. When both arrive in the same cycle, the set wins. secEdge has no effect in this mode.
- R7: With outMode = 7, flagState equals cntActive AND gateTick, sampled at the previous edge.
- R8: When forceEnable = 1 and extForce = 1, the next flag value is forceValue, whatever the mode and compare events say. When forceEnable = 0, extForce has no effect.
- R9: bcastOut is 1 in the cycle after an edge at which masterEnable = 1 and either cmp1Hit or cmp2Hit is 1. Otherwise it is 0.
- R10: When no debug force is applied, flagOut equals flagState XOR invertOut. The change is combinational.
- R11: idleReq = 1 loads idleLevel into the flag at the next edge, with priority over the force and over every mode. It also returns the outMode = 4 sequence to register 1.
- R12: When debugActive = 1 and debugAction is 2 or 3, flagOut is 0 while flagState keeps its value. Actions 0 and 1 leave flagOut unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| outMode | input | 3 | Output behaviour select, codes 0 to 7 |
| invertOut | input | 1 | Inverts the pin relative to the flag |
| forceEnable | input | 1 | Lets an external broadcast force the flag |
| extForce | input | 1 | Compare broadcast arriving from another channel |
| forceValue | input | 1 | Level loaded when a force is taken |
| masterEnable | input | 1 | Publish this channel's compare hits |
| idleReq | input | 1 | Load the idle level and restart the alternation |
| idleLevel | input | 1 | Level loaded on an idle request |
| debugActive | input | 1 | Chip is in debug state |
| debugAction | input | 2 | Debug action code; 2 and 3 pull the pin low |
| cntActive | input | 1 | Counter is counting |
| gateTick | input | 1 | Count-source tick for gated-clock output |
| cmp1Hit | input | 1 | Counter matched compare register 1 |
| cmp2Hit | input | 1 | Counter matched compare register 2 |
| secEdge | input | 1 | Selected edge on the secondary input |
| rollover | input | 1 | Counter rolled over |
| flagState | output | 1 | Internal flag, 1 meaning high |
| flagOut | output | 1 | Channel output pin |
| bcastOut | output | 1 | Registered compare broadcast to other channels |

## Verification
Each mode is first driven with event strobes that arrive alone, so set, clear, toggle and hold can be told apart. Each mode is then driven with strobes that collide in the same cycle, which shows set-over-clear and force-over-compare priority. The alternating mode gets hits from the register that is not due. This separates a correct turn pointer from a plain toggle on any compare, and a following idle request shows that the pointer restarts. A long stretch of mixed random strobes, modes and control levels is then compared cycle by cycle against a behavioural model. It also covers debug actions, polarity, and broadcast with master mode on and off.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

  localparam int MODE_W = 3;
  localparam int DBG_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ACTIVE      = 3'd0,
    MODE_CLEAR       = 3'd1,
    MODE_SET         = 3'd2,
    MODE_TOGGLE      = 3'd3,
    MODE_ALT_TOGGLE  = 3'd4,
    MODE_SET_SECCLR  = 3'd5,
    MODE_SET_ROLLCLR = 3'd6,
    MODE_GATED       = 3'd7
  } outModeE;

  // Strobes from control to the flag datapath. At most one action is raised per cycle.
  typedef struct packed {
    logic doLoad;
    logic loadVal;
    logic doSet;
    logic doClear;
    logic doToggle;
  } flagStrobeT;

endpackage

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl
  import cmp_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [MODE_W-1:0] outMode,
  input  logic             idleReq,
  input  logic             idleLevel,
  input  logic             forceEnable,
  input  logic             extForce,
  input  logic             forceValue,
  input  logic             cntActive,
  input  logic             gateTick,
  input  logic             cmp1Hit,
  input  logic             cmp2Hit,
  input  logic             secEdge,
  input  logic             rollover,
  output flagStrobeT       strobe
);

  // 0: waiting for register 1, 1: waiting for register 2
  logic altSel;
  logic altAdvance;
  logic altHit;
  logic forceTaken;

  assign forceTaken = forceEnable && extForce;
  assign altHit     = altSel ? cmp2Hit : cmp1Hit;

  always_comb begin
    strobe     = '0;
    altAdvance = 1'b0;
    if (idleReq) begin
      strobe.doLoad  = 1'b1;
      strobe.loadVal = idleLevel;
    end else if (forceTaken) begin
      strobe.doLoad  = 1'b1;
      strobe.loadVal = forceValue;
    end else begin
      case (outModeE'(outMode))
        MODE_ACTIVE: begin
          strobe.doLoad  = 1'b1;
          strobe.loadVal = cntActive;
        end
        MODE_CLEAR:  strobe.doClear  = cmp1Hit;
        MODE_SET:    strobe.doSet    = cmp1Hit;
        MODE_TOGGLE: strobe.doToggle = cmp1Hit;
        MODE_ALT_TOGGLE: begin
          strobe.doToggle = altHit;
          altAdvance      = altHit;
        end
        MODE_SET_SECCLR: begin
          strobe.doSet   = cmp1Hit;
          strobe.doClear = secEdge && !cmp1Hit;
        end
        MODE_SET_ROLLCLR: begin
          strobe.doSet   = cmp1Hit;
          strobe.doClear = rollover && !cmp1Hit;
        end
        MODE_GATED: begin
          strobe.doLoad  = 1'b1;
          strobe.loadVal = cntActive && gateTick;
        end
        default: strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      altSel <= 1'b0;
    end else if (idleReq) begin
      altSel <= 1'b0;
    end else if (altAdvance) begin
      altSel <= ~altSel;
    end
  end

endmodule

// File: rtl/cmp_flag_path.sv
module cmp_flag_path
  import cmp_flag_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobeT       strobe,
  input  logic             masterEnable,
  input  logic             cmp1Hit,
  input  logic             cmp2Hit,
  input  logic             invertOut,
  input  logic             debugActive,
  input  logic [DBG_W-1:0] debugAction,
  output logic             flagState,
  output logic             flagOut,
  output logic             bcastOut
);

  localparam int DBG_FORCE_BIT = DBG_W - 1;

  logic flagQ;
  logic bcastQ;
  logic pinLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= RESET_LEVEL;
    end else if (strobe.doLoad) begin
      flagQ <= strobe.loadVal;
    end else if (strobe.doSet) begin
      flagQ <= 1'b1;
    end else if (strobe.doClear) begin
      flagQ <= 1'b0;
    end else if (strobe.doToggle) begin
      flagQ <= ~flagQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcastQ <= 1'b0;
    end else begin
      bcastQ <= masterEnable && (cmp1Hit || cmp2Hit);
    end
  end

  assign pinLow    = debugActive && debugAction[DBG_FORCE_BIT];
  assign flagState = flagQ;
  assign flagOut   = pinLow ? 1'b0 : (flagQ ^ invertOut);
  assign bcastOut  = bcastQ;

endmodule

// File: rtl/cmp_flag_out.sv
module cmp_flag_out
  import cmp_flag_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       outMode,
  input  logic             invertOut,
  input  logic             forceEnable,
  input  logic             extForce,
  input  logic             forceValue,
  input  logic             masterEnable,
  input  logic             idleReq,
  input  logic             idleLevel,
  input  logic             debugActive,
  input  logic [1:0]       debugAction,
  input  logic             cntActive,
  input  logic             gateTick,
  input  logic             cmp1Hit,
  input  logic             cmp2Hit,
  input  logic             secEdge,
  input  logic             rollover,
  output logic             flagState,
  output logic             flagOut,
  output logic             bcastOut
);

  flagStrobeT strobe;

  cmp_flag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .outMode    (outMode),
    .idleReq    (idleReq),
    .idleLevel  (idleLevel),
    .forceEnable(forceEnable),
    .extForce   (extForce),
    .forceValue (forceValue),
    .cntActive  (cntActive),
    .gateTick   (gateTick),
    .cmp1Hit    (cmp1Hit),
    .cmp2Hit    (cmp2Hit),
    .secEdge    (secEdge),
    .rollover   (rollover),
    .strobe     (strobe)
  );

  cmp_flag_path #(.RESET_LEVEL(RESET_LEVEL)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .masterEnable(masterEnable),
    .cmp1Hit     (cmp1Hit),
    .cmp2Hit     (cmp2Hit),
    .invertOut   (invertOut),
    .debugActive (debugActive),
    .debugAction (debugAction),
    .flagState   (flagState),
    .flagOut     (flagOut),
    .bcastOut    (bcastOut)
  );

endmodule

// File: rtl/cmp_flag_chk.sv
module cmp_flag_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] outMode,
  input logic       invertOut,
  input logic       forceEnable,
  input logic       extForce,
  input logic       forceValue,
  input logic       masterEnable,
  input logic       idleReq,
  input logic       idleLevel,
  input logic       debugActive,
  input logic [1:0] debugAction,
  input logic       cntActive,
  input logic       cmp1Hit,
  input logic       cmp2Hit,
  input logic       flagState,
  input logic       flagOut,
  input logic       bcastOut
);

  logic quiet;
  assign quiet = !idleReq && !(forceEnable && extForce);

  p_mode0_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && outMode == 3'd0) |=> (flagState == $past(cntActive)));

  p_set_on_cmp_r3: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && outMode == 3'd2 && cmp1Hit) |=> flagState);

  p_toggle_on_cmp_r3: assert property (@(posedge clk) disable iff (!rstN)
    (quiet && outMode == 3'd3 && cmp1Hit) |=> (flagState != $past(flagState)));

  p_force_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!idleReq && forceEnable && extForce) |=> (flagState == $past(forceValue)));

  p_broadcast_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bcastOut == $past(masterEnable && (cmp1Hit || cmp2Hit))));

  p_polarity_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(debugActive && debugAction[1]) |-> (flagOut == (flagState ^ invertOut)));

  p_idle_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |=> (flagState == $past(idleLevel)));

  p_debug_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    (debugActive && debugAction[1]) |-> !flagOut);

endmodule

bind cmp_flag_out cmp_flag_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .outMode     (outMode),
  .invertOut   (invertOut),
  .forceEnable (forceEnable),
  .extForce    (extForce),
  .forceValue  (forceValue),
  .masterEnable(masterEnable),
  .idleReq     (idleReq),
  .idleLevel   (idleLevel),
  .debugActive (debugActive),
  .debugAction (debugAction),
  .cntActive   (cntActive),
  .cmp1Hit     (cmp1Hit),
  .cmp2Hit     (cmp2Hit),
  .flagState   (flagState),
  .flagOut     (flagOut),
  .bcastOut    (bcastOut)
);

// File: tb/cmp_flag_out_tb.sv
module cmp_flag_out_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] outMode;
  logic       invertOut, forceEnable, extForce, forceValue, masterEnable;
  logic       idleReq, idleLevel, debugActive;
  logic [1:0] debugAction;
  logic       cntActive, gateTick, cmp1Hit, cmp2Hit, secEdge, rollover;
  logic       flagState, flagOut, bcastOut;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  // behavioural reference state
  logic mFlag, mTurn2, mBc;

  always #5 clk = ~clk;

  cmp_flag_out u_dut (
    .clk(clk), .rstN(rstN), .outMode(outMode), .invertOut(invertOut),
    .forceEnable(forceEnable), .extForce(extForce), .forceValue(forceValue),
    .masterEnable(masterEnable), .idleReq(idleReq), .idleLevel(idleLevel),
    .debugActive(debugActive), .debugAction(debugAction), .cntActive(cntActive),
    .gateTick(gateTick), .cmp1Hit(cmp1Hit), .cmp2Hit(cmp2Hit), .secEdge(secEdge),
    .rollover(rollover), .flagState(flagState), .flagOut(flagOut), .bcastOut(bcastOut)
  );

  task automatic clearEvents();
    cmp1Hit = 0; cmp2Hit = 0; secEdge = 0; rollover = 0;
    extForce = 0; idleReq = 0; gateTick = 0;
  endtask

  task automatic modelEdge();
    logic nf, nt;
    nf = mFlag; nt = mTurn2;
    if (idleReq) begin
      nf = idleLevel; nt = 0;
    end else if (forceEnable && extForce) begin
      nf = forceValue;
    end else begin
      case (outMode)
        3'd0: nf = cntActive;
        3'd1: if (cmp1Hit) nf = 0;
        3'd2: if (cmp1Hit) nf = 1;
        3'd3: if (cmp1Hit) nf = ~mFlag;
        3'd4: if ((mTurn2 && cmp2Hit) || (!mTurn2 && cmp1Hit)) begin
                nf = ~mFlag; nt = ~mTurn2;
              end
        3'd5: if (cmp1Hit) nf = 1; else if (secEdge) nf = 0;
        3'd6: if (cmp1Hit) nf = 1; else if (rollover) nf = 0;
        default: nf = cntActive && gateTick;
      endcase
    end
    mBc = masterEnable && (cmp1Hit || cmp2Hit);
    mFlag = nf; mTurn2 = nt;
  endtask

  task automatic compareNow(string req);
    logic expPin;
    expPin = (debugActive && debugAction[1]) ? 1'b0 : (mFlag ^ invertOut);
    checks++;
    if (flagState !== mFlag || flagOut !== expPin || bcastOut !== mBc) begin
      failures++;
      $display("FAIL %s t=%0t actual state=%b pin=%b bcast=%b expected state=%b pin=%b bcast=%b",
               req, $time, flagState, flagOut, bcastOut, mFlag, expPin, mBc);
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc(string req);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareNow(req);
    clearEvents();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; outMode = 0; invertOut = 1; forceEnable = 0; forceValue = 0;
    masterEnable = 0; idleLevel = 0; debugActive = 0; debugAction = 0;
    cntActive = 1; clearEvents();
    cmp1Hit = 1; masterEnable = 1;
    mFlag = 0; mTurn2 = 0; mBc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareNow("R1");  // flag 0, pin = invertOut, no broadcast while in reset
    rstN = 1; cmp1Hit = 0; masterEnable = 0; cntActive = 0; invertOut = 0;
    cyc("R1");

    // R2: mode 0 follows the active level
    outMode = 3'd0;
    cntActive = 1; cyc("R2");
    cntActive = 1; cmp1Hit = 1; cyc("R2");
    cntActive = 0; cyc("R2");
    cntActive = 1; cyc("R2");
    cntActive = 0; cyc("R2");

    // R3: set, clear, toggle, and ignored strobes
    outMode = 3'd2; cmp2Hit = 1; secEdge = 1; rollover = 1; cyc("R3");
    cmp1Hit = 1; cyc("R3");
    cyc("R3");
    outMode = 3'd1; cmp2Hit = 1; cyc("R3");
    cmp1Hit = 1; cyc("R3");
    outMode = 3'd3; cmp1Hit = 1; cyc("R3");
    cmp1Hit = 1; cyc("R3");
    rollover = 1; cyc("R3");
    cmp1Hit = 1; cyc("R3");

    // R4: alternating registers, wrong-register hits ignored
    idleReq = 1; idleLevel = 0; cyc("R4");
    outMode = 3'd4;
    cmp2Hit = 1; cyc("R4");
    cmp1Hit = 1; cyc("R4");
    cmp1Hit = 1; cyc("R4");
    cmp2Hit = 1; cyc("R4");
    cmp2Hit = 1; cyc("R4");
    cmp1Hit = 1; cmp2Hit = 1; cyc("R4");
    cmp1Hit = 1; cmp2Hit = 1; cyc("R4");

    // R11: idle restarts the turn at register 1, wins over force
    cmp1Hit = 1; idleReq = 1; idleLevel = 0; cyc("R11");
    cmp1Hit = 1; cyc("R11");
    idleReq = 1; idleLevel = 1; cyc("R11");
    cmp2Hit = 1; cyc("R11");
    cmp1Hit = 1; cyc("R11");
    idleReq = 1; idleLevel = 1; forceEnable = 1; extForce = 1; forceValue = 0; cyc("R11");
    forceEnable = 0;

    // R5: secondary-edge clear, set wins on collision
    outMode = 3'd5;
    secEdge = 1; cyc("R5");
    cmp1Hit = 1; cyc("R5");
    secEdge = 1; cyc("R5");
    secEdge = 1; cmp1Hit = 1; cyc("R5");
    rollover = 1; cyc("R5");
    secEdge = 1; cyc("R5");

    // R6: rollover clear, secondary edge ignored
    outMode = 3'd6;
    cmp1Hit = 1; cyc("R6");
    secEdge = 1; cyc("R6");
    rollover = 1; cyc("R6");
    rollover = 1; cmp1Hit = 1; cyc("R6");
    rollover = 1; cyc("R6");

    // R7: gated tick output
    outMode = 3'd7;
    cntActive = 1; gateTick = 1; cyc("R7");
    cntActive = 1; gateTick = 0; cyc("R7");
    cntActive = 0; gateTick = 1; cyc("R7");
    cntActive = 1; gateTick = 1; cyc("R7");

    // R8: force priority and disable
    outMode = 3'd1;
    forceEnable = 1; extForce = 1; forceValue = 1; cmp1Hit = 1; cyc("R8");
    forceEnable = 0; extForce = 1; forceValue = 0; cyc("R8");
    forceEnable = 1; extForce = 0; forceValue = 0; cyc("R8");
    outMode = 3'd2; extForce = 1; forceValue = 0; cmp1Hit = 1; cyc("R8");
    forceEnable = 0;

    // R9: broadcast gated by master enable
    masterEnable = 1; cmp1Hit = 1; cyc("R9");
    cmp2Hit = 1; cyc("R9");
    cyc("R9");
    masterEnable = 0; cmp1Hit = 1; cmp2Hit = 1; cyc("R9");

    // R10: polarity
    invertOut = 1; cyc("R10");
    outMode = 3'd3; cmp1Hit = 1; cyc("R10");
    invertOut = 0; cyc("R10");

    // R12: debug actions
    for (int a = 0; a < 4; a++) begin
      debugActive = 1; debugAction = 2'(a); invertOut = 1; cyc("R12");
      invertOut = 0; cyc("R12");
    end
    debugActive = 0; debugAction = 0; cyc("R12");

    // mixed random traffic, compared every clock
    for (int i = 0; i < 1500; i++) begin
      outMode      = 3'($urandom_range(0, 7));
      cmp1Hit      = 1'($urandom_range(0, 1));
      cmp2Hit      = 1'($urandom_range(0, 1));
      secEdge      = 1'($urandom_range(0, 1));
      rollover     = 1'($urandom_range(0, 1));
      cntActive    = 1'($urandom_range(0, 1));
      gateTick     = 1'($urandom_range(0, 1));
      forceEnable  = 1'($urandom_range(0, 1));
      extForce     = ($urandom_range(0, 5) == 0);
      forceValue   = 1'($urandom_range(0, 1));
      idleReq      = ($urandom_range(0, 15) == 0);
      idleLevel    = 1'($urandom_range(0, 1));
      masterEnable = 1'($urandom_range(0, 1));
      invertOut    = 1'($urandom_range(0, 1));
      debugActive  = ($urandom_range(0, 3) == 0);
      debugAction  = 2'($urandom_range(0, 3));
      cyc("R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule